// File: doc/BRIEF.md
# Interrupt Status and Enable Controller

This block gathers interrupt requests from up to sixteen level-sensitive source lines and one software event, a write to a mailbox register. It holds them in a sticky status register. A per-bit enable register selects which pending bits may reach the host link. The block signals toward the link in one of two ways, chosen by an input. In level mode it drives a single interrupt line. In message mode it issues one-cycle request pulses, which a downstream message generator turns into message-signalled interrupts.

A small synchronous register port serves the software side. Status is read at offset 0x040, and writing 1 to a status bit clears it. The enable register is read and written at offset 0x050. Writing offset 0x800 stores a 32-bit mailbox word and raises the mailbox status bit. The hardware applies no priority among pending bits. Software reads the status and decides which source to service first.

The message-mode sequencer has four states:
- MSI_IDLE: nothing signalled.
- MSI_SEND: request pulse high.
- MSI_GAP: one quiet cycle before a pulse that is still owed.
- MSI_HOLD: pending bits already signalled.

Its transitions are:
- IDLE→SEND and HOLD→SEND on a new enabled bit.
- SEND→GAP when a new enabled bit arrives during the pulse.
- SEND→HOLD when bits are still pending.
- SEND→IDLE when nothing is pending.
- GAP→SEND always.
- HOLD→IDLE when nothing is pending.
- Any state→IDLE while level mode is selected.

Top module: `irq_gather_ctrl`

## Requirements
- R1: After reset, the status register, the enable register and the mailbox word are all zero, and both `legacy_irq` and `msi_req` are low.
- R2: A source line `irq_src[i]` sampled high at a clock edge sets status bit i at that edge. The bit stays set after the line falls.
- R3: A write to offset 0x800 stores `reg_wdata` as the mailbox word and sets status bit 16 (bit NUM_SRC). A read of 0x800 returns the stored word.
- R4: A write to offset 0x040 clears every status bit whose data bit is 1 and leaves bits written with 0 unchanged. If a source is high in the same cycle as its clear, the bit stays set.
- R5: A read at 0x040 returns status in bits 16:0, and a read at 0x050 returns the enable register. Bits above 16 read as zero, and unmapped offsets read as zero. Read data appears on `reg_rdata` the cycle after `reg_rd` and is held until the next read.
- R6: With `msi_mode`=0, `legacy_irq` equals the OR of status AND enable, taken from the register contents after each edge, and `msi_req` stays low.
- R7: A status bit whose enable bit is 0 raises neither output.
- R8: With `msi_mode`=1, `legacy_irq` is low. When a bit of status AND enable goes from 0 to 1 at edge k, `msi_req` is high for exactly the cycle between edges k+1 and k+2.
- R9: While the set of enabled pending bits does not grow, no further pulse is issued. A later newly set enabled bit, or enabling an already-set bit, produces another pulse.
- R10: `msi_req` is never high in two consecutive cycles. A new enabled bit that arrives during a pulse produces a second pulse after one low cycle.
- R11: Several sources asserted in the same cycle all latch, and together they produce a single pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msi_mode | input | 1 | 1 selects pulse (message) signalling, 0 selects the level line |
| irq_src | input | NUM_SRC | Level interrupt source lines |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data |
| legacy_irq | output | 1 | Level interrupt toward the link |
| msi_req | output | 1 | One-cycle message interrupt request |

## Verification
The bench first applies single isolated source pulses, held sources that race a clear, and a mailbox write. These tell sticky latching apart from level following, and show whether the clear or the set wins. It then sets several bits at once, sets new bits in the cycle of a pulse, and enables bits that were already set. These tell one pulse per rising pending condition apart from one pulse per bit, show the enforced gap between back-to-back pulses, and check that enabling a set bit counts as a new event. A long random phase then mixes mode switches, masks, clears and reads. Every cycle, the outputs are compared with a behavioural model of status, enable and owed pulses.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    typedef enum logic [1:0] {
        MSI_IDLE = 2'd0,
        MSI_SEND = 2'd1,
        MSI_GAP  = 2'd2,
        MSI_HOLD = 2'd3
    } msi_state_e;

    localparam logic [11:0] OFS_STATUS = 12'h040;
    localparam logic [11:0] OFS_ENABLE = 12'h050;
    localparam logic [11:0] OFS_MBOX   = 12'h800;

endpackage

// File: rtl/irqc_status.sv
module irqc_status #(
    parameter int NUM_SRC = 16,
    localparam int ST_W   = NUM_SRC + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_src,
    input  logic               mbox_set,
    input  logic [ST_W-1:0]    clr_mask,
    output logic [ST_W-1:0]    status_vec
);

    for (genvar i = 0; i < ST_W; i++) begin : g_bit
        logic set_i;
        logic bit_q;
        if (i < NUM_SRC) begin : g_src
            assign set_i = irq_src[i];
        end else begin : g_mbox
            assign set_i = mbox_set;
        end
        // set has priority over a simultaneous write-1 clear
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bit_q <= 1'b0;
            end else begin
                bit_q <= set_i | (bit_q & ~clr_mask[i]);
            end
        end
        assign status_vec[i] = bit_q;
    end

endmodule

// File: rtl/irqc_regif.sv
module irqc_regif
    import irqc_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32,
    parameter int ST_W    = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [ST_W-1:0]   status_vec,
    output logic [ST_W-1:0]   enable_vec,
    output logic [ST_W-1:0]   clr_mask,
    output logic              mbox_set,
    output logic [DATA_W-1:0] reg_rdata
);

    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
    localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(OFS_ENABLE);
    localparam logic [ADDR_W-1:0] A_MBOX   = ADDR_W'(OFS_MBOX);

    logic [ST_W-1:0]   enable_q;
    logic [DATA_W-1:0] mbox_q;
    logic [DATA_W-1:0] rdata_q;
    logic [DATA_W-1:0] rd_mux;
    logic              hit_status;
    logic              hit_enable;
    logic              hit_mbox;

    always_comb begin
        hit_status = (reg_addr == A_STATUS);
        hit_enable = (reg_addr == A_ENABLE);
        hit_mbox   = (reg_addr == A_MBOX);
    end

    assign clr_mask = (reg_wr && hit_status) ? reg_wdata[ST_W-1:0] : '0;
    assign mbox_set = reg_wr && hit_mbox;

    always_comb begin
        rd_mux = '0;
        if (hit_status) begin
            rd_mux[ST_W-1:0] = status_vec;
        end else if (hit_enable) begin
            rd_mux[ST_W-1:0] = enable_q;
        end else if (hit_mbox) begin
            rd_mux = mbox_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable_q <= '0;
            mbox_q   <= '0;
            rdata_q  <= '0;
        end else begin
            if (reg_wr && hit_enable) begin
                enable_q <= reg_wdata[ST_W-1:0];
            end
            if (mbox_set) begin
                mbox_q <= reg_wdata;
            end
            if (reg_rd) begin
                rdata_q <= rd_mux;
            end
        end
    end

    assign enable_vec = enable_q;
    assign reg_rdata  = rdata_q;

endmodule

// File: rtl/irqc_msi_fsm.sv
module irqc_msi_fsm
    import irqc_pkg::*;
#(
    parameter int ST_W = 17
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            msi_mode,
    input  logic [ST_W-1:0] masked,
    output logic            msi_req
);

    msi_state_e      state_q;
    msi_state_e      state_d;
    logic [ST_W-1:0] masked_q;
    logic            new_evt;
    logic            pending;

    assign new_evt = |(masked & ~masked_q);
    assign pending = |masked;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= MSI_IDLE;
            masked_q <= '0;
        end else begin
            state_q  <= state_d;
            masked_q <= masked;
        end
    end

    always_comb begin
        state_d = state_q;
        if (!msi_mode) begin
            state_d = MSI_IDLE;
        end else begin
            unique case (state_q)
                MSI_IDLE: if (new_evt) state_d = MSI_SEND;
                MSI_SEND: begin
                    if (new_evt)      state_d = MSI_GAP;
                    else if (pending) state_d = MSI_HOLD;
                    else              state_d = MSI_IDLE;
                end
                MSI_GAP:  state_d = MSI_SEND;
                MSI_HOLD: begin
                    if (new_evt)       state_d = MSI_SEND;
                    else if (!pending) state_d = MSI_IDLE;
                end
                default:  state_d = MSI_IDLE;
            endcase
        end
    end

    always_comb begin
        msi_req = msi_mode && (state_q == MSI_SEND);
    end

endmodule

// File: rtl/irq_gather_ctrl.sv
module irq_gather_ctrl #(
    parameter int NUM_SRC = 16,
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               msi_mode,
    input  logic [NUM_SRC-1:0] irq_src,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic               legacy_irq,
    output logic               msi_req
);

    localparam int ST_W = NUM_SRC + 1;

    logic [ST_W-1:0] status_vec;
    logic [ST_W-1:0] enable_vec;
    logic [ST_W-1:0] clr_mask;
    logic [ST_W-1:0] masked;
    logic            mbox_set;

    irqc_regif #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ST_W(ST_W)) u_regif (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .status_vec (status_vec),
        .enable_vec (enable_vec),
        .clr_mask   (clr_mask),
        .mbox_set   (mbox_set),
        .reg_rdata  (reg_rdata)
    );

    irqc_status #(.NUM_SRC(NUM_SRC)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_src    (irq_src),
        .mbox_set   (mbox_set),
        .clr_mask   (clr_mask),
        .status_vec (status_vec)
    );

    assign masked     = status_vec & enable_vec;
    assign legacy_irq = !msi_mode && (|masked);

    irqc_msi_fsm #(.ST_W(ST_W)) u_msi (
        .clk      (clk),
        .rst_n    (rst_n),
        .msi_mode (msi_mode),
        .masked   (masked),
        .msi_req  (msi_req)
    );

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = 16,
    parameter int ADDR_W  = 12,
    localparam int ST_W   = NUM_SRC + 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               msi_mode,
    input logic [NUM_SRC-1:0] irq_src,
    input logic               reg_wr,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic [ST_W-1:0]    wdata_lo,
    input logic [ST_W-1:0]    status_vec,
    input logic [ST_W-1:0]    enable_vec,
    input logic               legacy_irq,
    input logic               msi_req
);

    logic            wr_status;
    logic            wr_mbox;
    logic [ST_W-1:0] wr_clr;

    assign wr_status = reg_wr && (reg_addr == ADDR_W'(OFS_STATUS));
    assign wr_mbox   = reg_wr && (reg_addr == ADDR_W'(OFS_MBOX));
    assign wr_clr    = wr_status ? wdata_lo : '0;

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (status_vec == '0 && enable_vec == '0));

    p_src_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_src != '0) |=> ((status_vec[NUM_SRC-1:0] & $past(irq_src)) == $past(irq_src)));

    p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_vec & $past(status_vec & ~wr_clr)) == $past(status_vec & ~wr_clr)));

    p_mbox_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mbox |=> status_vec[NUM_SRC]);

    p_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_status |=> ((status_vec & $past(wdata_lo & ~{1'b0, irq_src})) == '0));

    p_no_pulse_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !msi_mode |-> !msi_req);

    p_masked_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_vec & enable_vec) == '0) |-> !legacy_irq);

    p_no_level_msi_r8: assert property (@(posedge clk) disable iff (!rst_n)
        msi_mode |-> !legacy_irq);

    p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        msi_req |=> !msi_req);

endmodule

bind irq_gather_ctrl irqc_checker #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .msi_mode   (msi_mode),
    .irq_src    (irq_src),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .wdata_lo   (reg_wdata[NUM_SRC:0]),
    .status_vec (status_vec),
    .enable_vec (enable_vec),
    .legacy_irq (legacy_irq),
    .msi_req    (msi_req)
);

// File: tb/irq_gather_ctrl_tb.sv
module irq_gather_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NSRC = 16;
    localparam int SW = NSRC + 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            msi_mode = 1'b0;
    logic [NSRC-1:0] irq_src = '0;
    logic            reg_wr = 1'b0;
    logic            reg_rd = 1'b0;
    logic [11:0]     reg_addr = '0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic            legacy_irq;
    logic            msi_req;

    irq_gather_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .msi_mode(msi_mode), .irq_src(irq_src),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .legacy_irq(legacy_irq), .msi_req(msi_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference state
    logic [SW-1:0] m_status = '0;
    logic [SW-1:0] m_en = '0;
    logic [SW-1:0] m_seen = '0;
    logic [31:0]   m_mbox = '0;
    logic [31:0]   m_rdata = '0;
    bit            m_req = 0;
    bit            m_owe = 0;
    int            vectors = 0;
    int            miscompares = 0;
    int            cycles = 0;
    string         cur_req = "R1";
    bit            done = 0;

    function automatic logic [31:0] model_read(logic [11:0] a);
        if (a == 12'h040) return 32'(m_status);
        if (a == 12'h050) return 32'(m_en);
        if (a == 12'h800) return m_mbox;
        return 32'h0;
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_status = '0; m_en = '0; m_seen = '0; m_mbox = '0;
            m_rdata = '0; m_req = 0; m_owe = 0;
        end else begin
            logic [SW-1:0] cur;
            logic [SW-1:0] clr;
            bit evt;
            bit nreq;
            cur = m_status & m_en;
            evt = (cur & ~m_seen) != 0;
            if (reg_rd) m_rdata = model_read(reg_addr);
            if (msi_mode) begin
                nreq  = !m_req && (evt || m_owe);
                m_owe = m_req && evt;
                m_req = nreq;
            end else begin
                m_req = 0; m_owe = 0;
            end
            m_seen = cur;
            clr = (reg_wr && reg_addr == 12'h040) ? reg_wdata[SW-1:0] : '0;
            m_status = (m_status & ~clr) | {(reg_wr && reg_addr == 12'h800), irq_src};
            if (reg_wr && reg_addr == 12'h050) m_en = reg_wdata[SW-1:0];
            if (reg_wr && reg_addr == 12'h800) m_mbox = reg_wdata;
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    // wait one cycle, then compare all outputs away from the active edge
    task automatic tick();
        bit exp_leg;
        bit exp_msi;
        @(negedge clk);
        exp_leg = !msi_mode && ((m_status & m_en) != 0);
        exp_msi = m_req && msi_mode;
        vectors++;
        if (legacy_irq !== exp_leg) begin
            miscompares++;
            $display("FAIL %s legacy_irq act=%0b exp=%0b t=%0t", cur_req, legacy_irq, exp_leg, $time);
        end
        if (msi_req !== exp_msi) begin
            miscompares++;
            $display("FAIL %s msi_req act=%0b exp=%0b t=%0t", cur_req, msi_req, exp_msi, $time);
        end
        if (reg_rdata !== m_rdata) begin
            miscompares++;
            $display("FAIL %s reg_rdata act=%h exp=%h t=%0t", cur_req, reg_rdata, m_rdata, $time);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 0;
    endtask

    task automatic rd(input logic [11:0] a);
        reg_rd = 1; reg_addr = a;
        tick();
        reg_rd = 0;
        tick();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        // watchdog
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog act=running exp=finished");
        finish_run();
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        idle(3);
        rst_n = 1;
        rd(12'h040); rd(12'h050); rd(12'h800);

        // R2: sticky source latch in level mode
        cur_req = "R2";
        wr(12'h050, 32'hFFFF_FFFF);
        irq_src = 16'h0008; tick(); irq_src = '0;
        idle(3); rd(12'h040);

        // R4: write-1 clear, zero bits untouched, set beats clear
        cur_req = "R4";
        irq_src = 16'h0001; tick(); irq_src = '0;
        wr(12'h040, 32'h0000_0008); rd(12'h040);
        irq_src = 16'h0020; wr(12'h040, 32'h0000_0021);
        irq_src = '0; rd(12'h040);
        wr(12'h040, 32'h0001_FFFF); rd(12'h040);

        // R3: mailbox write sets bit 16 and is readable
        cur_req = "R3";
        wr(12'h800, 32'hCAFE_0123); rd(12'h800); rd(12'h040);
        wr(12'h040, 32'h0001_0000);

        // R5: enable readback width and unmapped offsets
        cur_req = "R5";
        rd(12'h050); rd(12'h123); rd(12'h044);

        // R7: masked bit stays silent
        cur_req = "R7";
        wr(12'h050, 32'h0000_FF7F);
        irq_src = 16'h0080; tick(); irq_src = '0; idle(3);
        // R6: enabling the pending bit raises the level line
        cur_req = "R6";
        wr(12'h050, 32'h0001_FFFF); idle(2);
        wr(12'h040, 32'h0000_0080); idle(2);

        // R8: single pulse in message mode
        cur_req = "R8";
        msi_mode = 1; idle(2);
        irq_src = 16'h0002; tick(); irq_src = '0; idle(4);
        // R9: no repeat while pending, new bit pulses again
        cur_req = "R9";
        irq_src = 16'h0002; tick(); irq_src = '0; idle(3);
        irq_src = 16'h0400; tick(); irq_src = '0; idle(3);
        wr(12'h050, 32'h0000_0000);
        irq_src = 16'h1000; tick(); irq_src = '0; idle(2);
        wr(12'h050, 32'h0001_FFFF); idle(3);
        wr(12'h040, 32'h0001_FFFF); idle(2);
        // R11: simultaneous sources, one pulse
        cur_req = "R11";
        irq_src = 16'hF00F; tick(); irq_src = '0; idle(4); rd(12'h040);
        wr(12'h040, 32'h0001_FFFF); idle(2);
        // R10: new bit during the pulse gives a gap then a second pulse
        cur_req = "R10";
        irq_src = 16'h0001; tick(); irq_src = '0; tick();
        irq_src = 16'h0004; tick(); irq_src = '0; idle(5);
        irq_src = 16'h0100; tick(); irq_src = 16'h0200; tick();
        irq_src = 16'h0400; tick(); irq_src = '0; idle(5);
        wr(12'h040, 32'h0001_FFFF); idle(2);

        // mixed random phase
        cur_req = "R9";
        for (int n = 0; n < 4000; n++) begin
            int op;
            if ($urandom_range(0, 99) == 0) msi_mode = ~msi_mode;
            irq_src = ($urandom_range(0, 7) == 0) ? NSRC'(1 << $urandom_range(0, NSRC-1)) : '0;
            op = $urandom_range(0, 19);
            case (op)
                0: begin reg_wr = 1; reg_addr = 12'h040; reg_wdata = $urandom; end
                1: begin reg_wr = 1; reg_addr = 12'h050; reg_wdata = $urandom; end
                2: begin reg_wr = 1; reg_addr = 12'h800; reg_wdata = $urandom; end
                3: begin reg_rd = 1; reg_addr = 12'h040; end
                4: begin reg_rd = 1; reg_addr = 12'h050; end
                5: begin reg_rd = 1; reg_addr = 12'h800; end
                default: ;
            endcase
            tick();
            reg_wr = 0; reg_rd = 0;
        end
        irq_src = '0;
        idle(4);
        finish_run();
    end

endmodule